// File: doc/BRIEF.md
# Pipelined SHA-1 Compression Engine

This block applies the SHA-1 compression function to one 512-bit message block and one 160-bit chaining value on every clock. It returns the updated 160-bit digest a fixed number of cycles later. Each of the 80 rounds has its own register stage. There is also an input capture stage, a stage that starts the round state and a closing stage that adds the chaining value back in. A loop that runs many iterations, such as a key-stretching engine, can therefore keep as many independent computations in flight as the pipeline has stages. Padding, message splitting, keyed-hash wrapping and iteration control belong to the caller.

Both sides use a valid/ready handshake. An input is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is handed over on a rising edge where `out_valid` and `out_ready` are both high. If a result is presented and `out_ready` is low, every stage freezes. `in_ready` then stays low until the result leaves. The block never drops or reorders work. An 8-bit tag supplied with each input comes out beside its digest, so the caller can tell results apart.

Top module: `sha1_pipe`

## Requirements
- R1: With the standard initial chaining value 67452301_efcdab89_98badcfe_10325476_c3d2e1f0, a padded single block gives the standard digest. The block for "abc" gives a9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d, and the block for the empty message gives da39a3ee_5e6b4b0d_3255bfef_95601890_afd80709. Message word 0 is `in_block[511:480]`. Chaining word A is `in_chain[159:128]`, and digest word A is `out_digest[159:128]`.
- R2: An input accepted on rising edge N is presented on `out_valid` right after edge N+82, which is 83 edges counting edge N.
- R3: When the output is not stalled, one input is accepted on every clock. Inputs accepted on consecutive edges give results on consecutive cycles, in the order they were accepted.
- R4: `out_tag` equals the `in_tag` that was accepted together with the corresponding input.
- R5: Any 160-bit value may be used as the chaining value. Feeding the digest of the first block of the 448-bit message "abcdbcdecdefdefg...nopq" back in with the second block gives 84983e44_1c3bd26e_baae4aa1_f95129e5_e54670f1.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_digest` and `out_tag` hold their values. Once `out_ready` returns high, the held results leave on consecutive cycles with none lost.
- R7: After reset, `out_valid` is low and `in_ready` is high. Any work that was in flight when reset was applied never appears at the output.
- R8: A cycle in which no input is accepted produces no result. Gaps between inputs show up as equal gaps between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input block is offered |
| in_ready | output | 1 | The pipeline can advance and take an input |
| in_block | input | 512 | Message block, word 0 in the top bits |
| in_chain | input | 160 | Chaining value, word A in the top bits |
| in_tag | input | TAG_W | Caller's label, returned with the result |
| out_valid | output | 1 | A digest is presented |
| out_ready | input | 1 | The caller takes the presented digest |
| out_digest | output | 160 | Updated chaining value, word A in the top bits |
| out_tag | output | TAG_W | Label of the presented digest |

## Verification
The assertions assume the following:
- Reset is applied before the first input.
- `in_valid` and `out_ready` are clean levels at each rising edge.
- Nothing outside the handshake moves work into or out of the pipeline.

On that basis, the count of accepted but undelivered items must stay between zero and the pipeline depth, and no result may appear sooner than the full latency after reset.

The stimulus changes inputs only on falling edges. It keeps `out_ready` high except in the deliberate stall test. It offers inputs only while `in_ready` is high, or while the stall is known to be absent, so every accepted item is accounted for.

// File: rtl/sha1_pkg.sv
`timescale 1ns/1ps
package sha1_pkg;
  localparam int ROUNDS = 80;
  localparam int WIN    = 16;

  typedef logic [31:0] word_t;

  // Working state carried from one round stage to the next.
  typedef struct packed {
    word_t              a;
    word_t              b;
    word_t              c;
    word_t              d;
    word_t              e;
    word_t              p;   // K + W for the round this state enters
    logic [WIN-1:0][31:0] w; // schedule window
  } rstate_t;

  localparam logic [159:0] SHA1_IV =
    160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic word_t k_of(input int t);
    if (t < 20)      return 32'h5a827999;
    else if (t < 40) return 32'h6ed9eba1;
    else if (t < 60) return 32'h8f1bbcdc;
    else             return 32'hca62c1d6;
  endfunction

  function automatic word_t f_of(input int t, input word_t b, input word_t c,
                                 input word_t d);
    if (t < 20)      return (b & c) | (~b & d);
    else if (t < 40) return b ^ c ^ d;
    else if (t < 60) return (b & c) | (b & d) | (c & d);
    else             return b ^ c ^ d;
  endfunction
endpackage

// File: rtl/sha1_round.sv
`timescale 1ns/1ps
module sha1_round
  import sha1_pkg::*;
#(
  parameter int T   = 0,
  parameter int EXP = 4
) (
  input  logic    clk,
  input  logic    en,
  input  rstate_t din,
  output rstate_t dout
);
  // Window for group g holds W[g*EXP .. g*EXP+15]; refilled at group end.
  localparam int  G0       = (T / EXP) * EXP;
  localparam int  NEXT_IDX = T + 1 - G0;
  localparam bit  REGROUP  = ((T + 1) % EXP) == 0;
  localparam bit  LAST     = (T == ROUNDS - 1);
  localparam word_t K_NEXT = k_of(LAST ? 0 : T + 1);

  logic [31:0] ext [WIN+EXP];
  word_t       s_left, s_right, t_sum;
  rstate_t     nx;

  always_comb begin
    for (int i = 0; i < WIN; i++) ext[i] = din.w[i];
    for (int j = 0; j < EXP; j++) begin
      ext[WIN+j] = rotl(ext[WIN+j-3] ^ ext[WIN+j-8] ^
                        ext[WIN+j-14] ^ ext[WIN+j-16], 1);
    end
  end

  always_comb begin
    // Two adders in series at most: (rotl5(a)+f) + (e+K+W).
    s_left  = rotl(din.a, 5) + f_of(T, din.b, din.c, din.d);
    s_right = din.e + din.p;
    t_sum   = s_left + s_right;
    nx.a    = t_sum;
    nx.b    = din.a;
    nx.c    = rotl(din.b, 30);
    nx.d    = din.c;
    nx.e    = din.d;
    nx.p    = LAST ? '0 : K_NEXT + din.w[NEXT_IDX];
    for (int i = 0; i < WIN; i++) nx.w[i] = REGROUP ? ext[i+EXP] : din.w[i];
  end

  always_ff @(posedge clk) begin
    if (en) dout <= nx;
  end
endmodule

// File: rtl/sha1_cv_delay.sv
`timescale 1ns/1ps
module sha1_cv_delay #(
  parameter int DEPTH = 82,
  parameter int W     = 160
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst)     ptr <= '0;
    else if (en) ptr <= (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (en) mem[ptr] <= din;
  end

  // The slot about to be overwritten holds the value from DEPTH advances ago.
  assign dout = mem[ptr];
endmodule

// File: rtl/sha1_final_add.sv
`timescale 1ns/1ps
module sha1_final_add (
  input  logic         clk,
  input  logic         en,
  input  logic [159:0] chain,
  input  logic [159:0] work,
  output logic [159:0] digest
);
  logic [159:0] sum;

  always_comb begin
    for (int i = 0; i < 5; i++) begin
      sum[32*i +: 32] = chain[32*i +: 32] + work[32*i +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (en) digest <= sum;
  end
endmodule

// File: rtl/sha1_pipe.sv
`timescale 1ns/1ps
module sha1_pipe
  import sha1_pkg::*;
#(
  parameter int TAG_W         = 8,
  parameter int EXP_PER_STAGE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [511:0]     in_block,
  input  logic [159:0]     in_chain,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [159:0]     out_digest,
  output logic [TAG_W-1:0] out_tag
);
  localparam int LAT      = ROUNDS + 3;  // capture + init + rounds + add
  localparam int CV_DEPTH = ROUNDS + 2;  // capture edge to final-add input

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Capture stage: registers only.
  logic [511:0] blk_q;
  logic [159:0] cv_q;
  always_ff @(posedge clk) begin
    if (adv) begin
      blk_q <= in_block;
      cv_q  <= in_chain;
    end
  end

  // Valid and tag travel beside the data.
  logic [LAT-1:0]   vld;
  logic [TAG_W-1:0] tg [LAT];
  always_ff @(posedge clk) begin
    if (rst)      vld <= '0;
    else if (adv) vld <= {vld[LAT-2:0], in_valid};
  end
  always_ff @(posedge clk) begin
    if (adv) begin
      tg[0] <= in_tag;
      for (int i = 1; i < LAT; i++) tg[i] <= tg[i-1];
    end
  end

  // Initiation stage: load working variables, precompute K0 + W0.
  rstate_t init_nx, init_q;
  always_comb begin
    init_nx.a = cv_q[159:128];
    init_nx.b = cv_q[127:96];
    init_nx.c = cv_q[95:64];
    init_nx.d = cv_q[63:32];
    init_nx.e = cv_q[31:0];
    for (int i = 0; i < WIN; i++) init_nx.w[i] = blk_q[511-32*i -: 32];
    init_nx.p = k_of(0) + blk_q[511:480];
  end
  always_ff @(posedge clk) begin
    if (adv) init_q <= init_nx;
  end

  // Round stages.
  rstate_t st [ROUNDS];
  for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
    if (r == 0) begin : g_first
      sha1_round #(.T(r), .EXP(EXP_PER_STAGE)) u_rnd (
        .clk(clk), .en(adv), .din(init_q), .dout(st[r])
      );
    end else begin : g_next
      sha1_round #(.T(r), .EXP(EXP_PER_STAGE)) u_rnd (
        .clk(clk), .en(adv), .din(st[r-1]), .dout(st[r])
      );
    end
  end

  // Chaining value bypasses the rounds.
  logic [159:0] cv_dly;
  sha1_cv_delay #(.DEPTH(CV_DEPTH), .W(160)) u_cv (
    .clk(clk), .rst(rst), .en(adv), .din(in_chain), .dout(cv_dly)
  );

  logic [159:0] work_fin;
  logic [32*WIN+31:0] unused_tail;
  assign work_fin    = {st[ROUNDS-1].a, st[ROUNDS-1].b, st[ROUNDS-1].c,
                        st[ROUNDS-1].d, st[ROUNDS-1].e};
  assign unused_tail = {st[ROUNDS-1].p, st[ROUNDS-1].w};

  sha1_final_add u_fin (
    .clk(clk), .en(adv), .chain(cv_dly), .work(work_fin), .digest(out_digest)
  );

  assign out_valid = vld[LAT-1];
  assign out_tag   = tg[LAT-1];
endmodule

// File: rtl/sha1_pipe_chk.sv
`timescale 1ns/1ps
module sha1_pipe_chk #(
  parameter int TAG_W = 8,
  parameter int LAT   = 83
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [159:0]     out_digest,
  input logic [TAG_W-1:0] out_tag
);
  logic [7:0] inflight;
  logic [7:0] since_rst;
  logic       acc, fire;

  assign acc  = in_valid && in_ready;
  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight  <= '0;
      since_rst <= '0;
    end else begin
      inflight  <= inflight + 8'(acc) - 8'(fire);
      if (since_rst != 8'hff) since_rst <= since_rst + 8'd1;
    end
  end

  // R6: a refused result holds still
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_digest) && $stable(out_tag));

  // R6: no intake while the output is stalled
  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R2: nothing emerges before the full latency has passed since reset
  p_no_early_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst < 8'(LAT)) |-> !out_valid);

  // R3: occupancy never exceeds the number of stages
  p_depth_r3: assert property (@(posedge clk) disable iff (rst)
    inflight <= 8'(LAT));

  // R8: no result without a matching accepted input
  p_no_phantom_r8: assert property (@(posedge clk) disable iff (rst)
    (inflight == 8'd0) |-> !out_valid);
endmodule

bind sha1_pipe sha1_pipe_chk #(.TAG_W(TAG_W), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_digest(out_digest), .out_tag(out_tag)
);

// File: tb/sim_sha1_pipe.sv
`timescale 1ns/1ps
module sim_sha1_pipe;
  localparam int TAG_W = 8;
  localparam int LATENCY = 83;
  localparam logic [159:0] IV = 160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0;

  typedef struct packed {
    logic [511:0] blk;
    logic [159:0] exp;
  } vec_t;

  localparam vec_t VECS [2] = '{
    '{blk: {32'h61626380, 448'h0, 32'h00000018},
      exp: 160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d},
    '{blk: {32'h80000000, 480'h0},
      exp: 160'hda39a3ee_5e6b4b0d_3255bfef_95601890_afd80709}
  };

  localparam logic [511:0] LONG_B1 = {
    32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
    32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
    32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
    32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
  localparam logic [511:0] LONG_B2 = {480'h0, 32'h000001c0};
  localparam logic [159:0] LONG_EXP = 160'h84983e44_1c3bd26e_baae4aa1_f95129e5_e54670f1;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic             in_ready;
  logic [511:0]     in_block;
  logic [159:0]     in_chain;
  logic [TAG_W-1:0] in_tag;
  logic             out_valid;
  logic             out_ready;
  logic [159:0]     out_digest;
  logic [TAG_W-1:0] out_tag;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sha1_pipe #(.TAG_W(TAG_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .in_chain(in_chain), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_digest(out_digest), .out_tag(out_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Offer one input at a falling edge, then wait for a result.
  task automatic run_one(input logic [511:0] b, input logic [159:0] cv,
                         input logic [TAG_W-1:0] t, output logic [159:0] dg,
                         output logic [TAG_W-1:0] tg, output int lat);
    in_valid = 1'b1; in_block = b; in_chain = cv; in_tag = t;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    dg = out_digest;
    tg = out_tag;
  endtask

  task automatic wait_out(output int waited);
    waited = 0;
    while (!out_valid && waited < 300) begin
      @(negedge clk);
      waited++;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [159:0]     dg, held_dg, mid;
    logic [TAG_W-1:0] tg, held_tg;
    int               lat, w;
    bit               seen;

    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_block = '0; in_chain = '0; in_tag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R7: state after reset
    chk(out_valid == 1'b0, "R7", "out_valid after reset", 160'(out_valid), 160'd0);
    chk(in_ready == 1'b1, "R7", "in_ready after reset", 160'(in_ready), 160'd1);

    // Table walk: R1 digests, R2 latency, R4 tag
    for (int i = 0; i < 2; i++) begin
      run_one(VECS[i].blk, IV, TAG_W'(8'h10 + i), dg, tg, lat);
      chk(dg == VECS[i].exp, "R1", "single-block digest", dg, VECS[i].exp);
      chk(lat == LATENCY, "R2", "latency", 160'(lat), 160'(LATENCY));
      chk(tg == TAG_W'(8'h10 + i), "R4", "tag", 160'(tg), 160'(8'h10 + i));
      @(negedge clk);
    end

    // R3: six inputs on consecutive cycles
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_block = VECS[i%2].blk; in_chain = IV;
      in_tag = TAG_W'(8'h20 + i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_out(w);
    for (int i = 0; i < 6; i++) begin
      chk(out_valid == 1'b1, "R3", "consecutive result present", 160'(out_valid), 160'd1);
      chk(out_tag == TAG_W'(8'h20 + i), "R3", "result order", 160'(out_tag), 160'(8'h20 + i));
      chk(out_digest == VECS[i%2].exp, "R1", "back-to-back digest", out_digest, VECS[i%2].exp);
      @(negedge clk);
    end
    chk(out_valid == 1'b0, "R8", "no extra result after burst", 160'(out_valid), 160'd0);

    // R8: two idle cycles between inputs give two idle result cycles
    in_valid = 1'b1; in_block = VECS[0].blk; in_chain = IV; in_tag = 8'h40;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    in_valid = 1'b1; in_block = VECS[1].blk; in_tag = 8'h41;
    @(negedge clk);
    in_valid = 1'b0;
    wait_out(w);
    chk(out_tag == 8'h40, "R8", "first of gapped pair", 160'(out_tag), 160'h40);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "gap cycle 1", 160'(out_valid), 160'd0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "gap cycle 2", 160'(out_valid), 160'd0);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_tag == 8'h41, "R8", "second of gapped pair",
        160'(out_tag), 160'h41);
    chk(out_digest == VECS[1].exp, "R1", "gapped digest", out_digest, VECS[1].exp);
    @(negedge clk);

    // R6: back-pressure
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_block = VECS[i%2].blk; in_chain = IV;
      in_tag = TAG_W'(8'h50 + i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_out(w);
    held_dg = out_digest;
    held_tg = out_tag;
    chk(in_ready == 1'b0, "R6", "in_ready low during stall", 160'(in_ready), 160'd0);
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b1, "R6", "valid held", 160'(out_valid), 160'd1);
    chk(out_digest == held_dg, "R6", "digest held", out_digest, held_dg);
    chk(out_tag == held_tg && held_tg == 8'h50, "R6", "tag held", 160'(out_tag), 160'h50);
    out_ready = 1'b1;
    chk(out_digest == VECS[0].exp, "R6", "first stalled digest", out_digest, VECS[0].exp);
    @(negedge clk);
    chk(out_valid && out_tag == 8'h51, "R6", "second after release", 160'(out_tag), 160'h51);
    chk(out_digest == VECS[1].exp, "R6", "second stalled digest", out_digest, VECS[1].exp);
    @(negedge clk);
    chk(out_valid && out_tag == 8'h52, "R6", "third after release", 160'(out_tag), 160'h52);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "no duplicate after release", 160'(out_valid), 160'd0);

    // R5: chaining a non-initial value
    run_one(LONG_B1, IV, 8'h60, mid, tg, lat);
    @(negedge clk);
    run_one(LONG_B2, mid, 8'h61, dg, tg, lat);
    chk(dg == LONG_EXP, "R5", "two-block chained digest", dg, LONG_EXP);
    chk(tg == 8'h61, "R4", "chained tag", 160'(tg), 160'h61);
    @(negedge clk);

    // R7: reset discards work in flight
    in_valid = 1'b1; in_block = VECS[0].blk; in_chain = IV; in_tag = 8'h70;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    seen = 1'b0;
    chk(in_ready == 1'b1, "R7", "in_ready after mid reset", 160'(in_ready), 160'd1);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    chk(!seen, "R7", "flushed work never appears", 160'(seen), 160'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule